// File: doc/BRIEF.md
# Multi-Size Integer Add/Subtract Unit

This unit is the add/subtract slice of a 16-bit-class CPU datapath. One request carries a destination operand, a source operand (register value or immediate), an opcode, an operand size, a step code and the current condition flags. One cycle later the unit returns the result, the updated flags and a strobe that marks the result as valid. It covers plain add and subtract, add with carry and subtract with borrow, increment and decrement, address adjust by a small constant, and packed-BCD correction after an add or a subtract.

Some opcodes accept only some operand sizes and step values. When a request combines them in a way that is not allowed, the unit does not compute anything. It raises an illegal-request indication, and the surrounding decode logic can then trap. When the operation is narrower than 32 bits, only the low bits of the result change. The bits above the operand size are passed through from the destination, so the output can be written back to the full register.

Top module: `addsub_unit`

## Requirements
- R1: `res_valid` is high in the cycle after the one in which `req_valid` is high, and low otherwise. `res_data`, `flags_out` and `res_illegal` load only when a request is taken and hold between requests. After reset all outputs are 0.
- R2: Opcode 0 (add) and opcode 1 (subtract) accept size codes 0 (byte, 8 bits), 1 (word, 16 bits) and 2 (long, 32 bits). The source may be a register (`req_imm`=0) or an immediate (`req_imm`=1). The low size-width bits of `res_data` hold the result, and the bits above them are copied from `req_dst`.
- R3: A byte subtract with `req_imm`=1 is illegal. Any illegal request gives `res_illegal`=1, `res_data`=0 and `flags_out`=`req_flags`. Size code 3 and opcodes 10 to 15 are also illegal.
- R4: The flag vector is {H,N,Z,V,C} at bits [4:0] (C is bit 0, H is bit 4). For add and subtract the bits are set as follows:
  - N is the result MSB.
  - Z is set when the result is zero.
  - V marks two's-complement overflow.
  - C is the carry out of the MSB (borrow for subtract).
  - H is the carry or borrow out of bit 3, 11 or 27 for byte, word or long.
- R5: Opcode 2 (add with carry) and opcode 3 (subtract with borrow) are legal only at byte size. They add or subtract `req_flags` C in addition to the source.
- R6: For opcodes 2 and 3, Z becomes 0 when the result is nonzero and keeps its incoming value when the result is zero. The other flags follow R4.
- R7: Opcode 4 (increment) and opcode 5 (decrement) step the destination. The step code is 0 for 1, 1 for 2 and 2 for 4. A byte may step only by 1, and a word by 1 or 2. All other sizes and steps are illegal.
- R8: Increment and decrement update N, Z and V. C and H keep their incoming values.
- R9: Opcode 6 (address add) and opcode 7 (address subtract) are legal only at long size, with a step of 1, 2 or 4. Step code 3 is illegal.
- R10: The address add and subtract return `flags_out`=`req_flags`.
- R11: Opcode 8 (decimal adjust after add), byte only, applies two corrections to the byte:
  - It adds 0x06 when H is set or the low nibble is above 9.
  - It adds 0x60 when C is set or the byte is above 0x99.
- R12: Opcode 9 (decimal adjust after subtract), byte only, applies two corrections to the byte:
  - It subtracts 0x06 when H is set.
  - It subtracts 0x60 when C is set.
- R13: For both decimal-adjust opcodes, N and Z come from the corrected byte, C is set exactly when the 0x60 correction applied, and V and H keep their incoming values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Opcode |
| req_size | input | 2 | Operand size code |
| req_imm | input | 1 | Source is an immediate |
| req_step | input | 2 | Step code for increment, decrement and address adjust |
| req_dst | input | 32 | Destination operand |
| req_src | input | 32 | Source operand |
| req_flags | input | 5 | Incoming flags {H,N,Z,V,C} |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 32 | Result with pass-through upper bits |
| flags_out | output | 5 | Updated flags {H,N,Z,V,C} |
| res_illegal | output | 1 | Request combination is not allowed |

## Verification
Add and subtract are driven at each size with the following operand pairs:
- Pairs that cross the signed boundary separate V from C.
- Pairs that wrap to zero separate Z and C from N.
- Pairs that carry only within the low nibble isolate H at the right bit for each size.

Add with carry is run with the incoming Z set and clear against zero and nonzero results, which shows whether Z is sticky. Increment and decrement are run across the sign boundary and at zero to show that C and H are left alone. The decimal-adjust cases pick byte values that trigger only the low correction, only the high correction, both corrections, and corrections driven only by the flags.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_SZ = 3;
  localparam int FLAG_W = 5;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUBB  = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_AADD  = 4'd6,
    OP_ASUB  = 4'd7,
    OP_DADJA = 4'd8,
    OP_DADJS = 4'd9
  } op_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd1;
  localparam logic [1:0] SZ_L = 2'd2;

  localparam logic [1:0] ST_1 = 2'd0;
  localparam logic [1:0] ST_2 = 2'd1;
  localparam logic [1:0] ST_4 = 2'd2;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);

  localparam int HB = W - 4;

  logic [W-1:0] b_x;
  logic         c_x;
  logic [W:0]   full;
  logic [HB:0]  half;

  always_comb begin
    b_x  = sub ? ~b : b;
    c_x  = sub ? ~cin : cin;
    full = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, c_x};
    half = {1'b0, a[HB-1:0]} + {1'b0, b_x[HB-1:0]} + {{HB{1'b0}}, c_x};
    sum  = full[W-1:0];
    c_o  = full[W] ^ sub;
    h_o  = half[HB] ^ sub;
    if (sub) begin
      v_o = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
    end else begin
      v_o = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
  end

endmodule

// File: rtl/addsub_legal.sv
module addsub_legal
  import addsub_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] size,
  input  logic       imm,
  input  logic [1:0] step,
  output logic       legal
);

  always_comb begin
    legal = 1'b0;
    case (op)
      OP_ADD:            legal = (size != 2'd3);
      OP_SUB:            legal = (size != 2'd3) && !((size == SZ_B) && imm);
      OP_ADDC, OP_SUBB:  legal = (size == SZ_B);
      OP_INC, OP_DEC:    legal = ((size == SZ_B) && (step == ST_1)) ||
                                 ((size == SZ_W) && ((step == ST_1) || (step == ST_2)));
      OP_AADD, OP_ASUB:  legal = (size == SZ_L) && (step != 2'd3);
      OP_DADJA, OP_DADJS: legal = (size == SZ_B);
      default:           legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/addsub_decadj.sv
module addsub_decadj (
  input  logic [7:0] a,
  input  logic       sub,
  input  logic       c_in,
  input  logic       h_in,
  output logic [7:0] r,
  output logic       c_o
);

  logic       fix_lo;
  logic       fix_hi;
  logic [7:0] corr;

  always_comb begin
    fix_hi = c_in || (!sub && (a > 8'h99));
    fix_lo = h_in || (!sub && (a[3:0] > 4'd9));
    corr   = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
    r      = sub ? (a - corr) : (a + corr);
    c_o    = fix_hi;
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic              req_imm,
  input  logic [1:0]        req_step,
  input  logic [DATA_W-1:0] req_dst,
  input  logic [DATA_W-1:0] req_src,
  input  logic [FLAG_W-1:0] req_flags,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [FLAG_W-1:0] flags_out,
  output logic              res_illegal
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic legal;

  addsub_legal u_legal (
    .op    (req_op),
    .size  (req_size),
    .imm   (req_imm),
    .step  (req_step),
    .legal (legal)
  );

  // operand steering
  logic [DATA_W-1:0] step_val;
  logic [DATA_W-1:0] b_sel;
  logic              sub_sel;
  logic              cin_sel;
  flags_t            f_in;

  always_comb begin
    f_in = flags_t'(req_flags);
    case (req_step)
      ST_1:    step_val = DATA_W'(1);
      ST_2:    step_val = DATA_W'(2);
      ST_4:    step_val = DATA_W'(4);
      default: step_val = '0;
    endcase
    case (req_op)
      OP_INC, OP_DEC, OP_AADD, OP_ASUB: b_sel = step_val;
      default:                          b_sel = req_src;
    endcase
    sub_sel = (req_op == OP_SUB) || (req_op == OP_SUBB) ||
              (req_op == OP_DEC) || (req_op == OP_ASUB);
    cin_sel = ((req_op == OP_ADDC) || (req_op == OP_SUBB)) && f_in.c;
  end

  // one adder per operand size
  logic [DATA_W-1:0] merged [NUM_SZ];
  logic [NUM_SZ-1:0] neg_x;
  logic [NUM_SZ-1:0] zero_x;
  logic [NUM_SZ-1:0] cy_x;
  logic [NUM_SZ-1:0] hc_x;
  logic [NUM_SZ-1:0] ov_x;

  for (genvar gi = 0; gi < NUM_SZ; gi++) begin : g_sz
    localparam int W = 8 << gi;
    localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'({W{1'b1}}));
    logic [W-1:0] sum_w;

    addsub_core #(.W(W)) u_core (
      .a   (req_dst[W-1:0]),
      .b   (b_sel[W-1:0]),
      .sub (sub_sel),
      .cin (cin_sel),
      .sum (sum_w),
      .c_o (cy_x[gi]),
      .h_o (hc_x[gi]),
      .v_o (ov_x[gi])
    );

    assign merged[gi] = (req_dst & KEEP) | DATA_W'(sum_w);
    assign neg_x[gi]  = sum_w[W-1];
    assign zero_x[gi] = (sum_w == '0);
  end

  logic [1:0] sidx;
  assign sidx = (req_size == 2'd3) ? SZ_L : req_size;

  // decimal adjust
  logic [7:0] da_r;
  logic       da_c;

  addsub_decadj u_decadj (
    .a    (req_dst[7:0]),
    .sub  (req_op == OP_DADJS),
    .c_in (f_in.c),
    .h_in (f_in.h),
    .r    (da_r),
    .c_o  (da_c)
  );

  // next-state
  logic [DATA_W-1:0] nxt_data;
  flags_t            nxt_flags;
  logic              nxt_ill;

  always_comb begin
    nxt_data  = '0;
    nxt_flags = f_in;
    nxt_ill   = 1'b0;
    if (!legal) begin
      nxt_ill = 1'b1;
    end else begin
      case (req_op)
        OP_ADD, OP_SUB: begin
          nxt_data    = merged[sidx];
          nxt_flags.h = hc_x[sidx];
          nxt_flags.n = neg_x[sidx];
          nxt_flags.z = zero_x[sidx];
          nxt_flags.v = ov_x[sidx];
          nxt_flags.c = cy_x[sidx];
        end
        OP_ADDC, OP_SUBB: begin
          nxt_data    = merged[sidx];
          nxt_flags.h = hc_x[sidx];
          nxt_flags.n = neg_x[sidx];
          nxt_flags.z = f_in.z && zero_x[sidx];
          nxt_flags.v = ov_x[sidx];
          nxt_flags.c = cy_x[sidx];
        end
        OP_INC, OP_DEC: begin
          nxt_data    = merged[sidx];
          nxt_flags.n = neg_x[sidx];
          nxt_flags.z = zero_x[sidx];
          nxt_flags.v = ov_x[sidx];
        end
        OP_AADD, OP_ASUB: begin
          nxt_data = merged[sidx];
        end
        OP_DADJA, OP_DADJS: begin
          nxt_data    = {req_dst[DATA_W-1:8], da_r};
          nxt_flags.n = da_r[7];
          nxt_flags.z = (da_r == 8'h00);
          nxt_flags.c = da_c;
        end
        default: nxt_ill = 1'b1;
      endcase
    end
  end

  // registers, loaded under the request strobe
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      flags_out   <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_data    <= nxt_data;
        flags_out   <= nxt_flags;
        res_illegal <= nxt_ill;
      end
    end
  end

  // ---------------- assertions ----------------
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> res_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!res_valid && $stable(res_data) && $stable(flags_out)));

  p_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && legal && (req_size == SZ_B))
      |=> (res_data[DATA_W-1:8] == $past(req_dst[DATA_W-1:8])));

  p_byte_sub_imm_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (req_op == OP_SUB) && (req_size == SZ_B) && req_imm)
      |=> (res_illegal && (res_data == '0) && (flags_out == $past(req_flags))));

  p_chain_z_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && legal && ((req_op == OP_ADDC) || (req_op == OP_SUBB)) && !req_flags[2])
      |=> !flags_out[2]);

  p_incdec_keep_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && legal && ((req_op == OP_INC) || (req_op == OP_DEC)))
      |=> ((flags_out[0] == $past(req_flags[0])) && (flags_out[4] == $past(req_flags[4]))));

  p_addr_flags_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && legal && ((req_op == OP_AADD) || (req_op == OP_ASUB)))
      |=> (flags_out == $past(req_flags)));

  p_das_carry_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && legal && (req_op == OP_DADJS))
      |=> (flags_out[0] == $past(req_flags[0])));

endmodule

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [1:0]  req_size;
  logic        req_imm;
  logic [1:0]  req_step;
  logic [31:0] req_dst;
  logic [31:0] req_src;
  logic [4:0]  req_flags;
  logic        res_valid;
  logic [31:0] res_data;
  logic [4:0]  flags_out;
  logic        res_illegal;

  int n_vec;
  int n_bad;
  bit done;

  addsub_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_size    (req_size),
    .req_imm     (req_imm),
    .req_step    (req_step),
    .req_dst     (req_dst),
    .req_src     (req_src),
    .req_flags   (req_flags),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .flags_out   (flags_out),
    .res_illegal (res_illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // flag bits {H,N,Z,V,C}
  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FH = 4;

  function automatic bit is_legal(input logic [3:0] op, input logic [1:0] sz,
                                  input logic imm, input logic [1:0] st);
    case (op)
      4'd0:       return sz != 2'd3;
      4'd1:       return (sz != 2'd3) && !(sz == 2'd0 && imm);
      4'd2, 4'd3: return sz == 2'd0;
      4'd4, 4'd5: return (sz == 2'd0 && st == 2'd0) || (sz == 2'd1 && st <= 2'd1);
      4'd6, 4'd7: return (sz == 2'd2) && (st != 2'd3);
      4'd8, 4'd9: return sz == 2'd0;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic void model(input logic [3:0] op, input logic [1:0] sz,
                                input logic imm, input logic [1:0] st,
                                input logic [31:0] d, input logic [31:0] s,
                                input logic [4:0] f,
                                output logic [31:0] ed, output logic [4:0] ef,
                                output logic ei);
    int w;
    longint m, hm, a, b, full, half, sa, sb, sr, r, cin, stepn;
    bit issub, cf, hf, vf;
    ed = '0;
    ef = f;
    ei = !is_legal(op, sz, imm, st);
    if (ei) return;
    if (op == 4'd8 || op == 4'd9) begin
      logic [7:0] x;
      bit hi, lo;
      x  = d[7:0];
      if (op == 4'd8) begin
        hi = f[FC] || (x > 8'h99);
        lo = f[FH] || (x[3:0] > 4'd9);
        r  = (longint'(x) + (hi ? 'h60 : 0) + (lo ? 6 : 0)) & 'hFF;
      end else begin
        hi = f[FC];
        lo = f[FH];
        r  = (longint'(x) - (hi ? 'h60 : 0) - (lo ? 6 : 0)) & 'hFF;
      end
      ed = {d[31:8], r[7:0]};
      ef[FN] = r[7];
      ef[FZ] = (r == 0);
      ef[FC] = hi;
      return;
    end
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (longint'(1) << w) - 1;
    hm = (longint'(1) << (w - 4)) - 1;
    stepn = (st == 2'd0) ? 1 : (st == 2'd1) ? 2 : 4;
    a = longint'(d) & m;
    b = (op >= 4'd4) ? stepn : (longint'(s) & m);
    cin = (op == 4'd2 || op == 4'd3) ? longint'(f[FC]) : 0;
    issub = (op == 4'd1) || (op == 4'd3) || (op == 4'd5) || (op == 4'd7);
    sa = (a >= (longint'(1) << (w - 1))) ? a - (longint'(1) << w) : a;
    sb = (b >= (longint'(1) << (w - 1))) ? b - (longint'(1) << w) : b;
    if (issub) begin
      full = a - b - cin;
      half = (a & hm) - (b & hm) - cin;
      cf = full < 0;
      hf = half < 0;
      sr = sa - sb - cin;
    end else begin
      full = a + b + cin;
      half = (a & hm) + (b & hm) + cin;
      cf = full > m;
      hf = half > hm;
      sr = sa + sb + cin;
    end
    vf = (sr >= (longint'(1) << (w - 1))) || (sr < -(longint'(1) << (w - 1)));
    r  = full & m;
    ed = (d & ~(32'(m))) | 32'(r);
    case (op)
      4'd0, 4'd1: begin
        ef[FH] = hf; ef[FN] = r[w-1]; ef[FZ] = (r == 0); ef[FV] = vf; ef[FC] = cf;
      end
      4'd2, 4'd3: begin
        ef[FH] = hf; ef[FN] = r[w-1]; ef[FZ] = f[FZ] && (r == 0); ef[FV] = vf; ef[FC] = cf;
      end
      4'd4, 4'd5: begin
        ef[FN] = r[w-1]; ef[FZ] = (r == 0); ef[FV] = vf;
      end
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input string tag, input logic [3:0] op, input logic [1:0] sz,
                         input logic imm, input logic [1:0] st,
                         input logic [31:0] d, input logic [31:0] s,
                         input logic [4:0] f);
    logic [31:0] ed;
    logic [4:0]  ef;
    logic        ei;
    model(op, sz, imm, st, d, s, f, ed, ef, ei);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_imm = imm;
    req_step = st; req_dst = d; req_src = s; req_flags = f;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, res_valid === 1'b1 && res_illegal === ei && res_data === ed && flags_out === ef,
        $sformatf("op=%0d sz=%0d ill=%b/%b flags=%b/%b data", op, sz, res_illegal, ei,
                  flags_out, ef),
        res_data, ed);
  endtask

  task automatic t_reset;
    chk("R1", res_valid === 1'b0 && res_data === '0 && flags_out === '0 && res_illegal === 1'b0,
        "reset state", {res_valid, res_illegal, flags_out, res_data[24:0]}, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] last_d;
    logic [4:0]  last_f;
    run_vec("R1", 4'd0, 2'd1, 1'b0, 2'd0, 32'h0000_1234, 32'h0000_0001, 5'b0);
    last_d = res_data;
    last_f = flags_out;
    @(negedge clk);
    chk("R1", res_valid === 1'b0 && res_data === last_d && flags_out === last_f,
        "idle hold", res_data, last_d);
  endtask

  task automatic t_add_sub;
    run_vec("R4", 4'd0, 2'd0, 1'b0, 2'd0, 32'hAABB_CC7F, 32'h0000_0001, 5'b0);
    run_vec("R4", 4'd0, 2'd1, 1'b1, 2'd0, 32'h1111_FFFF, 32'h0000_0001, 5'b0);
    run_vec("R2", 4'd0, 2'd2, 1'b0, 2'd0, 32'h1234_5678, 32'h0FED_CBA9, 5'b11111);
    run_vec("R2", 4'd0, 2'd2, 1'b1, 2'd0, 32'h8000_0000, 32'h8000_0000, 5'b0);
    run_vec("R4", 4'd1, 2'd0, 1'b0, 2'd0, 32'h5566_7700, 32'h0000_0001, 5'b0);
    run_vec("R4", 4'd1, 2'd1, 1'b0, 2'd0, 32'h0000_8000, 32'h0000_0001, 5'b0);
    run_vec("R2", 4'd1, 2'd1, 1'b1, 2'd0, 32'hFFFF_0010, 32'h0000_0008, 5'b0);
    run_vec("R4", 4'd1, 2'd2, 1'b0, 2'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'b0);
    run_vec("R4", 4'd0, 2'd2, 1'b0, 2'd0, 32'h0000_000F, 32'h0000_0001, 5'b0);
  endtask

  task automatic t_illegal;
    run_vec("R3", 4'd1, 2'd0, 1'b1, 2'd0, 32'h0000_0055, 32'h0000_0011, 5'b10101);
    run_vec("R3", 4'd0, 2'd3, 1'b0, 2'd0, 32'h0000_0001, 32'h0000_0001, 5'b01010);
    run_vec("R3", 4'd12, 2'd0, 1'b0, 2'd0, 32'h0000_0001, 32'h0000_0001, 5'b00111);
  endtask

  task automatic t_carry_chain;
    run_vec("R5", 4'd2, 2'd0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0000_0000, 5'b00101);
    run_vec("R6", 4'd2, 2'd0, 1'b0, 2'd0, 32'h0000_00FE, 32'h0000_0001, 5'b00101);
    run_vec("R6", 4'd2, 2'd0, 1'b1, 2'd0, 32'h0000_0010, 32'h0000_0020, 5'b00101);
    run_vec("R6", 4'd2, 2'd0, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 5'b00000);
    run_vec("R5", 4'd3, 2'd0, 1'b0, 2'd0, 32'h0000_0010, 32'h0000_0001, 5'b00101);
    run_vec("R5", 4'd3, 2'd0, 1'b0, 2'd0, 32'h0000_0001, 32'h0000_0000, 5'b00101);
    run_vec("R5", 4'd2, 2'd1, 1'b0, 2'd0, 32'h0000_0001, 32'h0000_0001, 5'b00000);
  endtask

  task automatic t_incdec;
    run_vec("R7", 4'd4, 2'd0, 1'b0, 2'd0, 32'h0000_007F, 32'h0, 5'b10001);
    run_vec("R7", 4'd4, 2'd0, 1'b0, 2'd1, 32'h0000_0010, 32'h0, 5'b00000);
    run_vec("R8", 4'd4, 2'd1, 1'b0, 2'd1, 32'hABCD_7FFF, 32'h0, 5'b10001);
    run_vec("R8", 4'd5, 2'd0, 1'b0, 2'd0, 32'h0000_0080, 32'h0, 5'b00000);
    run_vec("R8", 4'd5, 2'd1, 1'b0, 2'd0, 32'h0000_0000, 32'h0, 5'b10000);
    run_vec("R7", 4'd4, 2'd2, 1'b0, 2'd0, 32'h0000_0001, 32'h0, 5'b00000);
    run_vec("R7", 4'd5, 2'd1, 1'b0, 2'd2, 32'h0000_0009, 32'h0, 5'b00000);
  endtask

  task automatic t_addr;
    run_vec("R10", 4'd6, 2'd2, 1'b0, 2'd2, 32'hFFFF_FFFE, 32'h0, 5'b01010);
    run_vec("R9", 4'd7, 2'd2, 1'b0, 2'd1, 32'h0000_0001, 32'h0, 5'b10100);
    run_vec("R9", 4'd6, 2'd2, 1'b0, 2'd0, 32'h1234_5678, 32'h0, 5'b00000);
    run_vec("R9", 4'd6, 2'd1, 1'b0, 2'd0, 32'h0000_0001, 32'h0, 5'b00000);
    run_vec("R9", 4'd7, 2'd2, 1'b0, 2'd3, 32'h0000_0010, 32'h0, 5'b00000);
  endtask

  task automatic t_decimal;
    run_vec("R11", 4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_003C, 32'h0, 5'b00000);
    run_vec("R11", 4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_009A, 32'h0, 5'b00000);
    run_vec("R11", 4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_0011, 32'h0, 5'b10000);
    run_vec("R13", 4'd8, 2'd0, 1'b0, 2'd0, 32'h7700_0012, 32'h0, 5'b00011);
    run_vec("R12", 4'd9, 2'd0, 1'b0, 2'd0, 32'h0000_002D, 32'h0, 5'b10000);
    run_vec("R12", 4'd9, 2'd0, 1'b0, 2'd0, 32'h0000_00F0, 32'h0, 5'b00001);
    run_vec("R13", 4'd9, 2'd0, 1'b0, 2'd0, 32'h0000_0066, 32'h0, 5'b10011);
    run_vec("R13", 4'd8, 2'd1, 1'b0, 2'd0, 32'h0000_0011, 32'h0, 5'b00000);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_size = '0; req_imm = 1'b0;
    req_step = '0; req_dst = '0; req_src = '0; req_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_hold;
    t_add_sub;
    t_illegal;
    t_carry_chain;
    t_incdec;
    t_addr;
    t_decimal;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule